// File: doc/BRIEF.md
# Section ID Extent Coalescer

This block turns a stream of granted section identifiers, arriving in ascending order, into a compact list of extents. Every run of back-to-back identifiers (each one greater than the one before it by exactly one) becomes a single 16-byte record. The record carries the identifier where the run begins, the number of sections in the run, and a reserved field that is always zero.

A record leaves the block only once its run has ended. A run ends either when a gap appears in the input or when the stream finishes. When a stream is complete, the block reports three values for the response header: the number of sections granted, the number of extents, and the total response length in bytes. The length is an 8-byte header plus 16 bytes for each extent.

An upstream allocator feeds identifiers through a valid/ready handshake with a last marker. A response builder drains records through a second valid/ready handshake. When the response builder holds off, the input stalls. A beat marked "no data" carries no identifier, so a stream that granted nothing can still be closed. Summary values apply only in the cycle their valid pulse is high.

Top module: `sect_extent_merge`

## Requirements
- R1: During and right after reset, `rec_valid` and `sum_valid` are 0 and `in_ready` is 1.
- R2: The first identifier of a stream opens an extent that starts at that identifier with a length of 1.
- R3: An identifier equal to the previous identifier plus one adds one to the length of the open extent and emits no record.
- R4: Any other identifier closes the open extent and emits it as a record. It then opens a new extent that starts at the new identifier with a length of 1.
- R5: Records are emitted in stream order, and only after their extent is closed. The extent still open when the last beat arrives is emitted after that beat, so a last beat that follows a gap produces two records.
- R6: `rec_rsvd` (the 64 reserved bits of each record) is zero on every record handed over.
- R7: After the final record of a stream has been accepted, `sum_valid` is high for exactly one cycle. In that cycle, `sum_sections` equals the number of identifier-carrying beats in the stream and `sum_extents` equals the number of records emitted. `sum_sections` is never less than `sum_extents`.
- R8: In the same cycle, `sum_bytes` equals 8 + 16 × `sum_extents`.
- R9: A stream made of a single beat with both `in_last` and `in_nodata` set produces no record and a summary of 0 sections, 0 extents and 8 bytes.
- R10: While `rec_valid` is 1 and `rec_ready` is 0, the record on the output does not change and `in_ready` is 0.
- R11: In the cycle after the last beat is accepted, `in_ready` is 0. It stays 0 until the summary pulse. The next stream then starts with its counts at zero.
- R12: A beat with `in_nodata` set and `in_last` clear is consumed without any effect on the extents or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input beat is offered |
| in_ready | output | 1 | The block accepts the offered beat |
| in_id | input | 32 | Granted section identifier |
| in_last | input | 1 | Final beat of the stream |
| in_nodata | input | 1 | The beat carries no identifier |
| rec_valid | output | 1 | An extent record is offered |
| rec_ready | input | 1 | The consumer takes the record |
| rec_start | output | 32 | First section identifier of the extent |
| rec_count | output | 32 | Number of sections in the extent |
| rec_rsvd | output | 64 | Reserved record bytes, always zero |
| sum_valid | output | 1 | One-cycle pulse with the end-of-stream summary |
| sum_sections | output | 32 | Granted sections in the stream |
| sum_extents | output | 32 | Extent records emitted for the stream |
| sum_bytes | output | 32 | Response length in bytes |

## Verification
The assertions assume two things about the input. First, identifiers within a stream rise strictly. Second, a stream never holds enough sections for the 32-bit counters or the byte length to wrap. Under those assumptions, every emitted record has a nonzero count, and the section total can never fall below the extent total. The stimulus draws each stream from ascending identifier tables that hold at most eight beats. One table climbs to the top of the identifier range without crossing it. The output is stalled both by a fixed pattern and by a long hold, so the checks on the stall and the held record are exercised.

// File: rtl/ext_pkg.sv
package ext_pkg;

    localparam int ID_W      = 32;
    localparam int RSVD_W    = 64;
    localparam int HDR_BYTES = 8;
    localparam int REC_BYTES = 16;

    typedef struct packed {
        logic [ID_W-1:0]   start;
        logic [ID_W-1:0]   count;
        logic [RSVD_W-1:0] rsvd;
    } ext_rec_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_SUM   = 2'd2
    } seq_state_e;

    // True when id follows prev with no gap; widened so the top value never wraps to zero.
    function automatic logic is_adjacent(input logic [ID_W-1:0] prev, input logic [ID_W-1:0] id);
        return {1'b0, id} == ({1'b0, prev} + {{ID_W{1'b0}}, 1'b1});
    endfunction

    function automatic logic [ID_W-1:0] resp_len(input logic [ID_W-1:0] n_ext);
        return ID_W'(HDR_BYTES) + n_ext * ID_W'(REC_BYTES);
    endfunction

endpackage

// File: rtl/ext_run_track.sv
module ext_run_track
    import ext_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            close_all,
    input  logic [ID_W-1:0] id,
    output logic            run_open,
    output logic            run_gap,
    output ext_rec_t        run_rec
);

    logic [ID_W-1:0] start_q;
    logic [ID_W-1:0] len_q;
    logic [ID_W-1:0] prev_q;
    logic            open_q;

    assign run_open = open_q;
    assign run_gap  = open_q && !is_adjacent(prev_q, id);

    always_comb begin
        run_rec       = '0;
        run_rec.start = start_q;
        run_rec.count = len_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            start_q <= '0;
            len_q   <= '0;
            prev_q  <= '0;
        end else if (take) begin
            prev_q <= id;
            if (!open_q || run_gap) begin
                start_q <= id;
                len_q   <= {{(ID_W-1){1'b0}}, 1'b1};
                open_q  <= 1'b1;
            end else begin
                len_q <= len_q + 1'b1;
            end
        end else if (close_all) begin
            open_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ext_rec_slot.sv
module ext_rec_slot
    import ext_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  ext_rec_t din,
    input  logic     rec_ready,
    output logic     rec_valid,
    output ext_rec_t dout,
    output logic     slot_free
);

    logic     valid_q;
    ext_rec_t data_q;

    assign rec_valid = valid_q;
    assign dout      = data_q;
    assign slot_free = !valid_q || rec_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= din;
        end else if (rec_ready) begin
            valid_q <= 1'b0;
        end
    end

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !rec_ready) |=> (valid_q && $stable(data_q))) else $error("held record changed"); // R10

    AST_REC_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (data_q.count != '0)) else $error("empty extent record"); // R5

endmodule

// File: rtl/ext_seq_ctrl.sv
module ext_seq_ctrl
    import ext_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic            in_nodata,
    input  logic            slot_free,
    input  logic            rec_valid,
    input  logic            run_open,
    input  logic            run_gap,
    output logic            in_ready,
    output logic            take,
    output logic            close_all,
    output logic            load,
    output logic            sum_valid,
    output logic [ID_W-1:0] sum_sections,
    output logic [ID_W-1:0] sum_extents,
    output logic [ID_W-1:0] sum_bytes
);

    seq_state_e      state_q;
    logic [ID_W-1:0] sect_q;
    logic [ID_W-1:0] ext_q;
    logic            accept;

    assign in_ready  = (state_q == ST_RUN) && slot_free;
    assign accept    = in_valid && in_ready;
    assign take      = accept && !in_nodata;
    assign close_all = (state_q == ST_FLUSH) && slot_free;
    assign load      = (take && run_gap) || (close_all && run_open);

    assign sum_valid    = (state_q == ST_SUM) && !rec_valid;
    assign sum_sections = sect_q;
    assign sum_extents  = ext_q;
    assign sum_bytes    = resp_len(ext_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            sect_q  <= '0;
            ext_q   <= '0;
        end else begin
            if (take) sect_q <= sect_q + 1'b1;
            if (load) ext_q  <= ext_q + 1'b1;
            case (state_q)
                ST_RUN:   if (accept && in_last) state_q <= ST_FLUSH;
                ST_FLUSH: if (slot_free) state_q <= ST_SUM;
                ST_SUM: begin
                    if (!rec_valid) begin
                        state_q <= ST_RUN;
                        sect_q  <= '0;
                        ext_q   <= '0;
                    end
                end
                default:  state_q <= ST_RUN;
            endcase
        end
    end

    AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        !slot_free |-> !in_ready) else $error("input open while output full"); // R10

    AST_LAST_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready) else $error("input open after last"); // R11

    AST_SUM_AFTER_RECS: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> !rec_valid) else $error("summary before final record"); // R7

    AST_SUM_PULSE: assert property (@(posedge clk) disable iff (rst)
        sum_valid |=> !sum_valid) else $error("summary longer than one cycle"); // R7

    AST_SECT_COVERS_EXT: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> (sum_sections >= sum_extents)) else $error("more extents than sections"); // R7

endmodule

// File: rtl/sect_extent_merge.sv
module sect_extent_merge
    import ext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ID_W-1:0]   in_id,
    input  logic              in_last,
    input  logic              in_nodata,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [ID_W-1:0]   rec_start,
    output logic [ID_W-1:0]   rec_count,
    output logic [RSVD_W-1:0] rec_rsvd,
    output logic              sum_valid,
    output logic [ID_W-1:0]   sum_sections,
    output logic [ID_W-1:0]   sum_extents,
    output logic [ID_W-1:0]   sum_bytes
);

    logic     take;
    logic     close_all;
    logic     load;
    logic     slot_free;
    logic     run_open;
    logic     run_gap;
    ext_rec_t run_rec;
    ext_rec_t out_rec;

    ext_run_track u_track (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .close_all (close_all),
        .id        (in_id),
        .run_open  (run_open),
        .run_gap   (run_gap),
        .run_rec   (run_rec)
    );

    ext_rec_slot u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .din       (run_rec),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .dout      (out_rec),
        .slot_free (slot_free)
    );

    ext_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_nodata    (in_nodata),
        .slot_free    (slot_free),
        .rec_valid    (rec_valid),
        .run_open     (run_open),
        .run_gap      (run_gap),
        .in_ready     (in_ready),
        .take         (take),
        .close_all    (close_all),
        .load         (load),
        .sum_valid    (sum_valid),
        .sum_sections (sum_sections),
        .sum_extents  (sum_extents),
        .sum_bytes    (sum_bytes)
    );

    assign rec_start = out_rec.start;
    assign rec_count = out_rec.count;
    assign rec_rsvd  = out_rec.rsvd;

endmodule

// File: tb/test_sect_extent_merge.sv
module test_sect_extent_merge;

    localparam int NV = 8;
    localparam int MAXB = 8;

    // Stimulus: id k of a vector sits at bits [k*32 +: 32]
    localparam logic [MAXB*32-1:0] TV_IDS [NV] = '{
        {224'd0, 32'd5},
        {128'd0, 32'd13, 32'd12, 32'd11, 32'd10},
        {128'd0, 32'd7, 32'd5, 32'd3, 32'd1},
        {64'd0, 32'd20, 32'd9, 32'd8, 32'd2, 32'd1, 32'd0},
        {96'd0, 32'd202, 32'd201, 32'd200, 32'd101, 32'd100},
        {32'hFFFFFFFF, 32'hFFFFFFFE, 32'hFFFFFFFD, 32'hFFFFFFFC,
         32'hFFFFFFFB, 32'hFFFFFFFA, 32'hFFFFFFF9, 32'hFFFFFFF8},
        {160'd0, 32'd10, 32'd9, 32'd7},
        {160'd0, 32'd10, 32'd8, 32'd7}
    };
    localparam int TV_N   [NV] = '{1, 4, 4, 6, 5, 8, 3, 3};
    localparam int TV_EXT [NV] = '{1, 1, 4, 3, 2, 1, 2, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_id = '0;
    logic        in_last = 1'b0;
    logic        in_nodata = 1'b0;
    logic        rec_valid;
    logic        rec_ready;
    logic [31:0] rec_start;
    logic [31:0] rec_count;
    logic [63:0] rec_rsvd;
    logic        sum_valid;
    logic [31:0] sum_sections;
    logic [31:0] sum_extents;
    logic [31:0] sum_bytes;

    sect_extent_merge i_sect_extent_merge (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
        .in_last(in_last), .in_nodata(in_nodata),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_start(rec_start), .rec_count(rec_count), .rec_rsvd(rec_rsvd),
        .sum_valid(sum_valid), .sum_sections(sum_sections),
        .sum_extents(sum_extents), .sum_bytes(sum_bytes)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int          rdy_mode = 0;
    int unsigned cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rdy_mode)
            0:       rec_ready = 1'b1;
            1:       rec_ready = cyc[0] ^ cyc[2];
            default: rec_ready = 1'b0;
        endcase
    end

    logic [31:0] cap_start [16];
    logic [31:0] cap_cnt   [16];
    int          ncap = 0;
    int          nsum = 0;
    logic [31:0] got_sect, got_ext, got_bytes;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rec_valid && rec_ready) begin
            if (ncap < 16) begin
                cap_start[ncap] = rec_start;
                cap_cnt[ncap]   = rec_count;
            end
            ncap++;
            chk(rec_rsvd == 64'd0, "R6 reserved bytes", rec_rsvd, 64'd0);
        end
        if (!rst && sum_valid) begin
            nsum++;
            got_sect  = sum_sections;
            got_ext   = sum_extents;
            got_bytes = sum_bytes;
        end
    end

    task automatic send_beat(input logic [31:0] id, input bit last, input bit nodata);
        @(negedge clk);
        in_valid  = 1'b1;
        in_id     = id;
        in_last   = last;
        in_nodata = nodata;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_nodata = 1'b0;
        if (last) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R11 input closed after last", in_ready, 0);
        end
    endtask

    task automatic wait_sum();
        for (int w = 0; w < 300 && nsum == 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Reference extents built from the requirements
    logic [31:0] m_start [MAXB];
    logic [31:0] m_cnt   [MAXB];
    int          m_n;

    task automatic model(input logic [MAXB*32-1:0] ids, input int n);
        m_n = 0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] v;
            v = ids[k*32 +: 32];
            if (k != 0 && v == ids[(k-1)*32 +: 32] + 32'd1) begin
                m_cnt[m_n-1] = m_cnt[m_n-1] + 1;
            end else begin
                m_start[m_n] = v;
                m_cnt[m_n]   = 1;
                m_n++;
            end
        end
    endtask

    task automatic run_vec(input int v);
        ncap = 0;
        nsum = 0;
        model(TV_IDS[v], TV_N[v]);
        for (int k = 0; k < TV_N[v]; k++)
            send_beat(TV_IDS[v][k*32 +: 32], k == TV_N[v]-1, 1'b0);
        wait_sum();
        chk(ncap == TV_EXT[v], "R5 record count", ncap, TV_EXT[v]);
        chk(m_n == TV_EXT[v], "R4 table extents", m_n, TV_EXT[v]);
        for (int k = 0; k < m_n && k < ncap; k++) begin
            chk(cap_start[k] == m_start[k], (k == 0) ? "R2 first start" : "R4 extent start",
                cap_start[k], m_start[k]);
            chk(cap_cnt[k] == m_cnt[k], "R3 extent length", cap_cnt[k], m_cnt[k]);
        end
        chk(nsum == 1, "R7 one summary pulse", nsum, 1);
        chk(got_sect == TV_N[v], "R7 section total", got_sect, TV_N[v]);
        chk(got_ext == TV_EXT[v], "R7 extent total", got_ext, TV_EXT[v]);
        chk(got_bytes == 8 + 16*TV_EXT[v], "R8 response bytes", got_bytes, 8 + 16*TV_EXT[v]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rec_valid == 1'b0, "R1 rec_valid in reset", rec_valid, 0);
        chk(sum_valid == 1'b0, "R1 sum_valid in reset", sum_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rec_valid == 1'b0 && sum_valid == 1'b0, "R1 outputs after reset", {rec_valid, sum_valid}, 0);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

        rdy_mode = 0;
        for (int v = 0; v < NV; v++) run_vec(v);
        rdy_mode = 1;
        for (int v = 0; v < NV; v++) run_vec(v);
        rdy_mode = 0;

        // R9: empty stream
        ncap = 0; nsum = 0;
        send_beat(32'd0, 1'b1, 1'b1);
        wait_sum();
        chk(ncap == 0, "R9 no records", ncap, 0);
        chk(nsum == 1 && got_sect == 0 && got_ext == 0, "R9 zero counts", {got_sect, got_ext}, 0);
        chk(got_bytes == 32'd8, "R9 header only length", got_bytes, 8);

        // R12: no-data beat inside a stream
        ncap = 0; nsum = 0;
        send_beat(32'd4, 1'b0, 1'b0);
        send_beat(32'd77, 1'b0, 1'b1);
        send_beat(32'd5, 1'b1, 1'b0);
        wait_sum();
        chk(ncap == 1 && cap_start[0] == 4 && cap_cnt[0] == 2, "R12 no-data beat ignored",
            {cap_start[0], cap_cnt[0]}, {32'd4, 32'd2});
        chk(got_sect == 2, "R12 section total unchanged", got_sect, 2);

        // R10: long hold on the output
        ncap = 0; nsum = 0;
        rdy_mode = 2;
        send_beat(32'd1, 1'b0, 1'b0);
        send_beat(32'd5, 1'b0, 1'b0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(rec_valid && rec_start == 1 && rec_count == 1, "R10 record held",
                {rec_start, rec_count}, {32'd1, 32'd1});
            chk(in_ready == 1'b0, "R10 input stalled", in_ready, 0);
        end
        rdy_mode = 0;
        send_beat(32'd9, 1'b1, 1'b0);
        wait_sum();
        chk(ncap == 3 && cap_start[1] == 5 && cap_start[2] == 9, "R10 records after release",
            {cap_start[1], cap_start[2]}, {32'd5, 32'd9});
        chk(got_bytes == 32'd56, "R8 three extents", got_bytes, 56);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule